// File: doc/BRIEF.md
# Interrupt Redirection Register Front End

This block is the software-visible register face of an I/O interrupt controller. A 32-bit memory-mapped slave port offers two main locations: a select register that names an internal register, and a data window that reads or writes whatever the select register names. Behind the window sit a 4-bit controller ID (visible at two select values), a read-only version word, and a table of redirection entries, one 64-bit entry per interrupt pin. Software reaches each entry one 32-bit half at a time.

The table keeps two status bits under hardware control. The delivery-status bit follows an input from the delivery logic. The remote-IRR bit is set and cleared by strobes from that logic. Software writes never alter either bit, but a write that leaves an entry in edge mode scrubs remote IRR. After each accepted table write the block pulses a notification carrying the entry index. Downstream logic uses this pulse to reset that pin's storm counter and start a service pass. When the VERSION parameter is 0x20, an end-of-interrupt location passes a written vector to the rest of the controller.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset every entry reads as 0x00010000 (low half, mask bit 16 set) and 0x00000000 (high half), the ID and the select register are 0, and no pulse outputs are active.
- R2: Offset 0x00 is the select register. It accepts a write of any size, keeps wdata bits 7:0, and reads back zero-extended. Every read returns its data on rdata_o with rvalid_o one cycle after the request.
- R3: Only address bits 7:0 are decoded: 0x00 is the select register, 0x10 the data window, 0x40 the end-of-interrupt location. Any other offset reads as zero, and writes to it have no effect.
- R4: Data-window and end-of-interrupt accesses act only when size_i is 4 (bytes). A narrower window read returns zero, and a narrower write changes nothing.
- R5: A window write with select 0 stores wdata bits 27:24 as the ID. Reads with select 0 or select 2 return the ID in bits 27:24 and zeros elsewhere. Window writes with select 1 or 2 are ignored.
- R6: A window read with select 1 returns VERSION in bits 7:0 and PINS-1 in bits 23:16, with zeros elsewhere.
- R7: Select 0x10+2n reaches bits 31:0 of entry n, and select 0x11+2n reaches bits 63:32, for n < PINS. Any select value that is not 0, 1 or 2 and not in that range reads as zero, and window writes to it have no effect.
- R8: Entry bits 12 (delivery status) and 14 (remote IRR) are never changed by a table write. Bit 12 shows dstat_i as registered one cycle earlier. Bit 14 is set by rirr_set_i and cleared by rirr_clr_i, and set wins when both are active.
- R9: After a table write, if entry bit 15 (trigger mode, 1 = level) is 0, entry bit 14 reads 0. A write to a level-mode entry leaves bit 14 as it was.
- R10: Each accepted table write makes tbl_wr_o high for one cycle, in the next cycle, with tbl_idx_o holding the entry index. No other access raises tbl_wr_o.
- R11: With VERSION 0x20, a 4-byte write to offset 0x40 makes eoi_valid_o high in the next cycle, with eoi_vec_o equal to wdata bits 7:0. With any other VERSION, or with a narrower write, eoi_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset within the 4 KiB region |
| size_i | input | 3 | Access size in bytes (1, 2 or 4) |
| wdata_i | input | 32 | Write data |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |
| rdata_o | output | 32 | Read data |
| rirr_set_i | input | PINS | Per-pin remote-IRR set strobe from delivery logic |
| rirr_clr_i | input | PINS | Per-pin remote-IRR clear strobe |
| dstat_i | input | PINS | Per-pin delivery status level |
| tbl_wr_o | output | 1 | Pulse after an accepted table write |
| tbl_idx_o | output | $clog2(PINS) (5) | Index of the written entry |
| eoi_valid_o | output | 1 | End-of-interrupt vector valid |
| eoi_vec_o | output | 8 | End-of-interrupt vector |

## Verification
The bench targets the edges of the table range, entry 23 and the first select value past it. A decoder with an off-by-one error would alias a fixed register or write past the table there. It writes 1s and 0s over the two hardware-owned bits: a front end that masks them wrongly would show software values in place of remote IRR or delivery status. It writes edge and level entries both with remote IRR set, which catches a scrub that is missing or one that fires in level mode. It also sends narrow window and end-of-interrupt writes, mirrored high offsets, and the same end-of-interrupt write to an instance built with version 0x11. A design that ignores size, decodes too many address bits or tests the wrong version would then corrupt state or forward a vector.

// File: rtl/irqr_pkg.sv
package irqr_pkg;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;

  localparam int B_DSTAT = 12;
  localparam int B_RIRR  = 14;
  localparam int B_TRIG  = 15;
  localparam int B_MASK  = 16;
  localparam int ID_LSB  = 24;
  localparam int CNT_LSB = 16;

  localparam logic [2:0] FULL_SIZE = 3'd4;
  localparam logic [7:0] EOI_VERSION = 8'h20;

  typedef enum logic [1:0] {ACC_NONE, ACC_SEL, ACC_WIN, ACC_EOI} acc_e;
  typedef enum logic [2:0] {TGT_NONE, TGT_ID, TGT_VER, TGT_ARB, TGT_TBL} tgt_e;
endpackage

// File: rtl/irqr_decode.sv
module irqr_decode
  import irqr_pkg::*;
#(
  parameter int PINS = 24,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic [11:0]      addr_i,
  input  logic [2:0]       size_i,
  input  logic [7:0]       sel_i,
  output acc_e             acc_o,
  output logic             full_o,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  logic [7:0] off;
  logic [6:0] half;
  logic       in_tbl;
  logic       unused_hi_addr;

  assign unused_hi_addr = ^addr_i[11:8];
  assign off    = sel_i - SEL_TBL;
  assign half   = off[7:1];
  assign in_tbl = (sel_i >= SEL_TBL) && (int'(half) < PINS);
  assign idx_o  = half[IDX_W-1:0];
  assign hi_o   = sel_i[0];
  assign full_o = (size_i == FULL_SIZE);

  always_comb begin
    unique case (addr_i[7:0])
      OFF_SEL: acc_o = ACC_SEL;
      OFF_WIN: acc_o = ACC_WIN;
      OFF_EOI: acc_o = ACC_EOI;
      default: acc_o = ACC_NONE;
    endcase
  end

  always_comb begin
    unique case (sel_i)
      SEL_ID:  tgt_o = TGT_ID;
      SEL_VER: tgt_o = TGT_VER;
      SEL_ARB: tgt_o = TGT_ARB;
      default: tgt_o = in_tbl ? TGT_TBL : TGT_NONE;
    endcase
  end
endmodule

// File: rtl/irqr_entry.sv
module irqr_entry
  import irqr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  input  logic        rirr_clr_i,
  input  logic        dstat_i,
  output logic [63:0] entry_o
);
  localparam logic [63:0] ENT_RST = 64'h1 << B_MASK;

  logic [63:0] ent_q, ent_d;
  logic        rirr_nxt;

  always_comb begin
    ent_d = ent_q;
    if (wr_lo_i) ent_d[31:0]  = wdata_i;
    if (wr_hi_i) ent_d[63:32] = wdata_i;
    // hardware owns these two bits
    rirr_nxt = ent_q[B_RIRR];
    if (rirr_clr_i) rirr_nxt = 1'b0;
    if (rirr_set_i) rirr_nxt = 1'b1;
    ent_d[B_RIRR]  = rirr_nxt;
    ent_d[B_DSTAT] = dstat_i;
    if ((wr_lo_i || wr_hi_i) && !ent_d[B_TRIG]) ent_d[B_RIRR] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ent_q <= ENT_RST;
    else         ent_q <= ent_d;
  end

  assign entry_o = ent_q;
endmodule

// File: rtl/irqr_rdmux.sv
module irqr_rdmux
  import irqr_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int         ID_W    = 4,
  localparam int IDX_W = $clog2(PINS)
) (
  input  tgt_e                  tgt_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  logic                  hi_i,
  input  logic [ID_W-1:0]       id_i,
  input  logic [PINS-1:0][63:0] entries_i,
  output logic [31:0]           data_o
);
  localparam logic [7:0] MAX_PIN = 8'(PINS - 1);

  always_comb begin
    data_o = '0;
    unique case (tgt_i)
      TGT_ID, TGT_ARB: data_o[ID_LSB +: ID_W] = id_i;
      TGT_VER: begin
        data_o[7:0]           = VERSION;
        data_o[CNT_LSB +: 8]  = MAX_PIN;
      end
      TGT_TBL: data_o = hi_i ? entries_i[idx_i][63:32] : entries_i[idx_i][31:0];
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_redir_regs.sv
module irq_redir_regs
  import irqr_pkg::*;
#(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h20,
  parameter int         ID_W    = 4,
  localparam int IDX_W = $clog2(PINS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [11:0]      addr_i,
  input  logic [2:0]       size_i,
  input  logic [31:0]      wdata_i,
  output logic             rvalid_o,
  output logic [31:0]      rdata_o,
  input  logic [PINS-1:0]  rirr_set_i,
  input  logic [PINS-1:0]  rirr_clr_i,
  input  logic [PINS-1:0]  dstat_i,
  output logic             tbl_wr_o,
  output logic [IDX_W-1:0] tbl_idx_o,
  output logic             eoi_valid_o,
  output logic [7:0]       eoi_vec_o
);
  localparam bit EOI_ON = (VERSION == EOI_VERSION);

  logic [7:0]            sel_q;
  logic [ID_W-1:0]       id_q;
  acc_e                  acc;
  tgt_e                  tgt;
  logic                  full, hi;
  logic [IDX_W-1:0]      idx;
  logic                  wr, rd, win_wr, tbl_wr, eoi_hit;
  logic [31:0]           win_data, rd_data;
  logic [PINS-1:0][63:0] entries;

  irqr_decode #(.PINS(PINS)) u_dec (
    .addr_i (addr_i),
    .size_i (size_i),
    .sel_i  (sel_q),
    .acc_o  (acc),
    .full_o (full),
    .tgt_o  (tgt),
    .idx_o  (idx),
    .hi_o   (hi)
  );

  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign win_wr  = wr && (acc == ACC_WIN) && full;
  assign tbl_wr  = win_wr && (tgt == TGT_TBL);
  assign eoi_hit = EOI_ON && wr && (acc == ACC_EOI) && full;

  for (genvar g = 0; g < PINS; g++) begin : g_ent
    irqr_entry u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_lo_i    (tbl_wr && !hi && (idx == IDX_W'(g))),
      .wr_hi_i    (tbl_wr &&  hi && (idx == IDX_W'(g))),
      .wdata_i    (wdata_i),
      .rirr_set_i (rirr_set_i[g]),
      .rirr_clr_i (rirr_clr_i[g]),
      .dstat_i    (dstat_i[g]),
      .entry_o    (entries[g])
    );
  end

  irqr_rdmux #(.PINS(PINS), .VERSION(VERSION), .ID_W(ID_W)) u_rdmux (
    .tgt_i     (tgt),
    .idx_i     (idx),
    .hi_i      (hi),
    .id_i      (id_q),
    .entries_i (entries),
    .data_o    (win_data)
  );

  always_comb begin
    unique case (acc)
      ACC_SEL: rd_data = {24'h0, sel_q};
      ACC_WIN: rd_data = full ? win_data : 32'h0;
      default: rd_data = 32'h0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= '0;
      id_q        <= '0;
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
      tbl_wr_o    <= 1'b0;
      tbl_idx_o   <= '0;
      eoi_valid_o <= 1'b0;
      eoi_vec_o   <= '0;
    end else begin
      rvalid_o    <= rd;
      rdata_o     <= rd ? rd_data : 32'h0;
      tbl_wr_o    <= tbl_wr;
      eoi_valid_o <= eoi_hit;
      if (tbl_wr)  tbl_idx_o <= idx;
      if (eoi_hit) eoi_vec_o <= wdata_i[7:0];
      if (wr && acc == ACC_SEL) sel_q <= wdata_i[7:0];
      if (win_wr && tgt == TGT_ID) id_q <= wdata_i[ID_LSB +: ID_W];
    end
  end
endmodule

// File: rtl/irqr_regs_chk.sv
module irqr_regs_chk #(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h20,
  localparam int IDX_W = $clog2(PINS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [11:0]      addr_i,
  input logic [2:0]       size_i,
  input logic [31:0]      wdata_i,
  input logic             rvalid_o,
  input logic [31:0]      rdata_o,
  input logic             tbl_wr_o,
  input logic [IDX_W-1:0] tbl_idx_o,
  input logic             eoi_valid_o,
  input logic [7:0]       eoi_vec_o
);
  logic unused_ver;
  assign unused_ver = ^VERSION;

  AST_RVALID_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && !we_i)); // R2

  AST_NARROW_WIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i[7:0] == 8'h10 && size_i != 3'd4)) |-> (rdata_o == 32'h0)); // R4

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && $past(addr_i[7:0] != 8'h00 && addr_i[7:0] != 8'h10)) |-> (rdata_o == 32'h0)); // R3

  AST_TBL_WR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> $past(req_i && we_i && addr_i[7:0] == 8'h10 && size_i == 3'd4)); // R10

  AST_TBL_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_wr_o |-> (int'(tbl_idx_o) < PINS)); // R7

  AST_EOI_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_valid_o |-> ($past(req_i && we_i && addr_i[7:0] == 8'h40 && size_i == 3'd4)
                     && eoi_vec_o == $past(wdata_i[7:0]))); // R11
endmodule

bind irq_redir_regs irqr_regs_chk #(.PINS(PINS), .VERSION(VERSION)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .size_i      (size_i),
  .wdata_i     (wdata_i),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .tbl_wr_o    (tbl_wr_o),
  .tbl_idx_o   (tbl_idx_o),
  .eoi_valid_o (eoi_valid_o),
  .eoi_vec_o   (eoi_vec_o)
);

// File: tb/irq_redir_regs_test.sv
`timescale 1ns/1ps
module irq_redir_regs_test;
  localparam int PINS = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, use_b = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0;
  logic [PINS-1:0] rset = '0, rclr = '0, dst = '0;

  logic        rv_a, rv_b, tw_a, tw_b, ev_a, ev_b;
  logic [31:0] rd_a, rd_b;
  logic [4:0]  ti_a, ti_b;
  logic [7:0]  vec_a, vec_b;

  int checks = 0;
  int errors = 0;
  logic [31:0] rdv;
  logic        s_tw, s_ev, s_rv;
  logic [4:0]  s_ti;
  logic [7:0]  s_vec;

  always #2.5 clk = ~clk;

  irq_redir_regs #(.PINS(PINS), .VERSION(8'h20)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req & ~use_b), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rv_a), .rdata_o(rd_a),
    .rirr_set_i(rset), .rirr_clr_i(rclr), .dstat_i(dst),
    .tbl_wr_o(tw_a), .tbl_idx_o(ti_a), .eoi_valid_o(ev_a), .eoi_vec_o(vec_a));

  irq_redir_regs #(.PINS(PINS), .VERSION(8'h11)) uut_v11 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req & use_b), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rvalid_o(rv_b), .rdata_o(rd_b),
    .rirr_set_i(rset), .rirr_clr_i(rclr), .dstat_i(dst),
    .tbl_wr_o(tw_b), .tbl_idx_o(ti_b), .eoi_valid_o(ev_b), .eoi_vec_o(vec_b));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic sample();
    s_rv  = use_b ? rv_b  : rv_a;
    rdv   = use_b ? rd_b  : rd_a;
    s_tw  = use_b ? tw_b  : tw_a;
    s_ti  = use_b ? ti_b  : ti_a;
    s_ev  = use_b ? ev_b  : ev_a;
    s_vec = use_b ? vec_b : vec_a;
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; size = sz; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
    sample();
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [2:0] sz);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a; size = sz;
    @(negedge clk); req = 1'b0;
    sample();
    check("R2 rvalid", {31'h0, s_rv}, 32'h1);
  endtask

  task automatic rd_win(input logic [7:0] sel, output logic [31:0] v);
    bus_wr(12'h000, 3'd4, {24'h0, sel});
    bus_rd(12'h010, 3'd4);
    v = rdv;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(12'h000, 3'd4);       check("R1 select reset", rdv, 32'h0);
    check("R1 no tbl pulse", {31'h0, s_tw}, 32'h0);
    rd_win(8'h10, v);            check("R1 entry0 lo", v, 32'h0001_0000);
    rd_win(8'h3F, v);            check("R1 entry23 hi", v, 32'h0);
    rd_win(8'h00, v);            check("R1 id reset", v, 32'h0);
  endtask

  task automatic t_select();
    bus_wr(12'h000, 3'd4, 32'h0000_03A5);
    bus_rd(12'h000, 3'd4);       check("R2 select 8 bits", rdv, 32'h0000_00A5);
    bus_wr(12'h000, 3'd1, 32'h0000_0012);
    bus_rd(12'h000, 3'd1);       check("R2 select narrow", rdv, 32'h0000_0012);
  endtask

  task automatic t_id_ver();
    logic [31:0] v;
    bus_wr(12'h000, 3'd4, 32'h0);
    bus_wr(12'h010, 3'd4, 32'hFF00_0000);
    check("R10 no pulse on id write", {31'h0, s_tw}, 32'h0);
    rd_win(8'h00, v);            check("R5 id read", v, 32'h0F00_0000);
    rd_win(8'h02, v);            check("R5 arb read", v, 32'h0F00_0000);
    bus_wr(12'h010, 3'd4, 32'h0);
    rd_win(8'h02, v);            check("R5 arb write ignored", v, 32'h0F00_0000);
    rd_win(8'h01, v);            check("R6 version", v, 32'h0017_0020);
    bus_wr(12'h010, 3'd4, 32'hFFFF_FFFF);
    bus_rd(12'h010, 3'd4);       check("R5 version write ignored", rdv, 32'h0017_0020);
  endtask

  task automatic t_table();
    logic [31:0] v;
    bus_wr(12'h000, 3'd4, 32'h1A);
    bus_wr(12'h010, 3'd4, 32'h0000_8031);
    check("R10 pulse lo", {31'h0, s_tw}, 32'h1);
    check("R10 idx 5", {27'h0, s_ti}, 32'd5);
    bus_rd(12'h010, 3'd4);       check("R7 entry5 lo", rdv, 32'h0000_8031);
    bus_wr(12'h000, 3'd4, 32'h1B);
    bus_wr(12'h010, 3'd4, 32'hAB00_0000);
    check("R10 pulse hi", {31'h0, s_tw}, 32'h1);
    rd_win(8'h1B, v);            check("R7 entry5 hi", v, 32'hAB00_0000);
    bus_wr(12'h000, 3'd4, 32'h3E);
    bus_wr(12'h010, 3'd4, 32'h0000_0055);
    check("R10 idx 23", {27'h0, s_ti}, 32'd23);
    rd_win(8'h3E, v);            check("R7 entry23 lo", v, 32'h0000_0055);
    rd_win(8'h1C, v);            check("R7 entry6 untouched", v, 32'h0001_0000);
    bus_wr(12'h000, 3'd4, 32'h40);
    bus_wr(12'h010, 3'd4, 32'h1234_5678);
    check("R7 past table no pulse", {31'h0, s_tw}, 32'h0);
    bus_rd(12'h010, 3'd4);       check("R7 past table reads 0", rdv, 32'h0);
    rd_win(8'h05, v);            check("R7 gap select reads 0", v, 32'h0);
  endtask

  task automatic t_narrow_offset();
    logic [31:0] v;
    bus_wr(12'h000, 3'd4, 32'h1A);
    bus_wr(12'h010, 3'd2, 32'h0);
    check("R4 narrow write no pulse", {31'h0, s_tw}, 32'h0);
    bus_rd(12'h010, 3'd2);       check("R4 narrow read zero", rdv, 32'h0);
    bus_rd(12'h010, 3'd4);       check("R4 entry intact", rdv, 32'h0000_8031);
    bus_rd(12'h110, 3'd4);       check("R3 mirrored window", rdv, 32'h0000_8031);
    bus_wr(12'h020, 3'd4, 32'h0);
    bus_rd(12'h020, 3'd4);       check("R3 unmapped reads 0", rdv, 32'h0);
    bus_rd(12'h000, 3'd4);       check("R3 unmapped write ignored", rdv, 32'h0000_001A);
    rd_win(8'h1A, v);            check("R3 entry after unmapped write", v, 32'h0000_8031);
  endtask

  task automatic pulse_set(input int p);
    @(negedge clk); rset[p] = 1'b1;
    @(negedge clk); rset[p] = 1'b0;
  endtask

  task automatic t_ro_bits();
    logic [31:0] v;
    pulse_set(5);
    rd_win(8'h1A, v);            check("R8 rirr set", v, 32'h0000_C031);
    bus_wr(12'h010, 3'd4, 32'h0000_9031);
    bus_rd(12'h010, 3'd4);       check("R8 ro bits kept", rdv, 32'h0000_C031);
    @(negedge clk); dst[5] = 1'b1;
    bus_rd(12'h010, 3'd4);       check("R8 dstat follows", rdv, 32'h0000_D031);
    bus_wr(12'h010, 3'd4, 32'h0000_8031);
    bus_rd(12'h010, 3'd4);       check("R8 dstat not written", rdv, 32'h0000_D031);
    @(negedge clk); dst[5] = 1'b0;
    bus_wr(12'h000, 3'd4, 32'h1B);
    bus_wr(12'h010, 3'd4, 32'h0100_0000);
    rd_win(8'h1A, v);            check("R9 level keeps rirr", v, 32'h0000_C031);
    @(negedge clk); rset[5] = 1'b1; rclr[5] = 1'b1;
    @(negedge clk); rset[5] = 1'b0;
    @(negedge clk); rclr[5] = 1'b0;
    bus_rd(12'h010, 3'd4);       check("R8 clr after set", rdv, 32'h0000_8031);
    pulse_set(5);
    bus_wr(12'h010, 3'd4, 32'h0000_0031);
    bus_rd(12'h010, 3'd4);       check("R9 edge scrub", rdv, 32'h0000_0031);
  endtask

  task automatic t_eoi();
    logic [31:0] v;
    bus_wr(12'h040, 3'd4, 32'h1234_5677);
    check("R11 eoi valid", {31'h0, s_ev}, 32'h1);
    check("R11 eoi vector", {24'h0, s_vec}, 32'h77);
    bus_wr(12'h040, 3'd2, 32'h0000_0011);
    check("R11 narrow eoi ignored", {31'h0, s_ev}, 32'h0);
    use_b = 1'b1;
    bus_wr(12'h040, 3'd4, 32'h0000_0033);
    check("R11 v11 no eoi", {31'h0, s_ev}, 32'h0);
    rd_win(8'h01, v);            check("R6 v11 version", v, 32'h0017_0011);
    use_b = 1'b0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_id_ver();
    t_table();
    t_narrow_offset();
    t_ro_bits();
    t_eoi();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule